// File: doc/BRIEF.md
# Processor-to-Logic Byte Mailbox

This block moves single bytes from a slow processor bus clock domain into a faster logic clock domain without ever synchronizing the data word itself. The processor writes a byte into a holding register. It then writes 0 and then 1 to a one-bit strobe register. Only that strobe crosses the clock boundary. It passes through a two-flop synchronizer and a third flop in the logic domain. The rising edge seen there produces a one-cycle capture enable. That enable loads the destination register from the holding register, which the processor keeps unchanged until the capture has happened.

A four-phase handshake protects the holding register. A logic-domain ready flag drops when a byte is captured, and the processor sees it through a synchronizer as `cpu_ready`. The processor answers by setting an acknowledge bit, which is synchronized into the logic domain. The ready flag then rises again. The processor clears the acknowledge, and the next byte may follow.

The handshake is a three-state machine in the logic domain:
- **MB_READY**: the ready flag is high and a strobe edge is accepted.
- **MB_TAKEN**: a byte was captured and the ready flag is low.
- **MB_ACKED**: the acknowledge was seen, the ready flag is high, and the machine waits for the acknowledge to drop.

Its transitions are:
- **capture**: MB_READY to MB_TAKEN, on the capture enable.
- **ack_seen**: MB_TAKEN to MB_ACKED, when the synchronized acknowledge is 1.
- **ack_clear**: MB_ACKED to MB_READY, when the synchronized acknowledge is 0.

A strobe edge is ignored in every state other than MB_READY.

Top module: `mbx_bridge`

## Requirements
- R1: While either reset is high, and after both resets release with no strobe write, `out_valid` stays 0 and `out_byte` stays 0. `cpu_ready` is 0 during bus reset and becomes 1 within a few bus cycles after both resets release.
- R2: Writing the data register (address 0) without a strobe 0-then-1 sequence produces no capture.
- R3: A strobe rising edge, made by writing bit 0 of address 1 as 0 then 1, accepted in MB_READY, loads `out_byte` with the held byte. `out_valid` is then high for exactly one logic cycle.
- R4: `out_byte` changes only in a cycle where `out_valid` is high.
- R5: After a capture, `cpu_ready` falls. After the processor writes 1 to bit 0 of address 2 (acknowledge), `cpu_ready` rises again.
- R6: A strobe rising edge made while in MB_TAKEN, before the acknowledge, is ignored. No capture occurs, and `out_byte` keeps the earlier byte.
- R7: A sequence of bytes, each sent with the full handshake, is captured exactly once each and in order.
- R8: Writing 1 to the strobe while it is already 1 is not an edge and captures nothing.
- R9: A strobe edge made while in MB_ACKED, with the acknowledge still 1, is ignored. After the acknowledge is cleared, the next strobe edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| logic_clk | input | 1 | Fast logic clock |
| logic_rst | input | 1 | Active-high synchronous reset, logic domain |
| bus_clk | input | 1 | Processor bus clock |
| bus_rst | input | 1 | Active-high synchronous reset, bus domain |
| bus_we | input | 1 | Bus write strobe, one bus cycle per write |
| bus_addr | input | 2 | 0 = data, 1 = strobe (bit 0), 2 = acknowledge (bit 0) |
| bus_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Ready flag synchronized into the bus domain |
| out_byte | output | DATA_W | Captured byte |
| out_valid | output | 1 | One-cycle pulse marking a new captured byte |

## Verification
Some properties are checked by the assertions on every logic cycle:
- `out_valid` is a single-cycle pulse.
- `out_byte` never moves outside such a pulse.
- The ready flag is low whenever a byte is presented.
- Every capture leaves MB_READY.

Other behaviour needs the bench's scenarios, because it spans both clocks and whole handshakes:
- Every byte arrives once and in order.
- A repeated strobe write, or an early or late strobe edge, is dropped.
- `cpu_ready` follows the handshake as the processor sees it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        MB_READY = 2'd0,
        MB_TAKEN = 2'd1,
        MB_ACKED = 2'd2
    } mb_state_e;

    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_STROBE = 2'd1;
    localparam logic [1:0] ADDR_ACK    = 2'd2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[TOP-1:0], d};
        end
    end

    assign q = chain[TOP];
endmodule

// File: rtl/mbx_cpu_regs.sv
module mbx_cpu_regs
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] held_data,
    output logic              strobe_q,
    output logic              ack_q
);
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            held_data <= '0;
            strobe_q  <= 1'b0;
            ack_q     <= 1'b0;
        end else if (bus_we) begin
            unique case (bus_addr)
                ADDR_DATA:   held_data <= bus_wdata;
                ADDR_STROBE: strobe_q  <= bus_wdata[0];
                ADDR_ACK:    ack_q     <= bus_wdata[0];
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              logic_clk,
    input  logic              logic_rst,
    input  logic              strobe_s,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] held_data,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_valid,
    output logic              ready_q
);
    mb_state_e state_q, state_n;
    logic      strobe_d3;
    logic      strobe_rise;
    logic      capture_en;

    // third flop and rising-edge detect
    always_ff @(posedge logic_clk) begin
        if (logic_rst) begin
            strobe_d3 <= 1'b0;
        end else begin
            strobe_d3 <= strobe_s;
        end
    end

    assign strobe_rise = strobe_s & ~strobe_d3;
    assign capture_en  = strobe_rise && (state_q == MB_READY);

    // state register
    always_ff @(posedge logic_clk) begin
        if (logic_rst) begin
            state_q <= MB_READY;
        end else begin
            state_q <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            MB_READY: if (capture_en) state_n = MB_TAKEN;
            MB_TAKEN: if (ack_s)      state_n = MB_ACKED;
            MB_ACKED: if (!ack_s)     state_n = MB_READY;
            default:                  state_n = MB_READY;
        endcase
    end

    // registered outputs
    always_ff @(posedge logic_clk) begin
        if (logic_rst) begin
            out_byte  <= '0;
            out_valid <= 1'b0;
            ready_q   <= 1'b0;
        end else begin
            out_valid <= capture_en;
            ready_q   <= (state_n != MB_TAKEN);
            if (capture_en) begin
                out_byte <= held_data;
            end
        end
    end

    // R3
    valid_one_cycle_chk: assert property (@(posedge logic_clk) disable iff (logic_rst)
        out_valid |=> !out_valid);

    // R4
    byte_hold_chk: assert property (@(posedge logic_clk) disable iff (logic_rst)
        !out_valid |-> $stable(out_byte));

    // R5
    ready_low_on_capture_chk: assert property (@(posedge logic_clk) disable iff (logic_rst)
        out_valid |-> !ready_q);

    // R6
    capture_from_ready_chk: assert property (@(posedge logic_clk) disable iff (logic_rst)
        $rose(out_valid) |-> ($past(state_q) == MB_READY) && (state_q == MB_TAKEN));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              logic_clk,
    input  logic              logic_rst,
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_valid
);
    logic [DATA_W-1:0] held_data;
    logic              strobe_q;
    logic              ack_q;
    logic              strobe_s;
    logic              ack_s;
    logic              ready_q;

    mbx_cpu_regs #(.DATA_W(DATA_W)) u_regs (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .held_data (held_data),
        .strobe_q  (strobe_q),
        .ack_q     (ack_q)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_strobe (
        .clk (logic_clk),
        .rst (logic_rst),
        .d   (strobe_q),
        .q   (strobe_s)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk (logic_clk),
        .rst (logic_rst),
        .d   (ack_q),
        .q   (ack_s)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ready (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ready_q),
        .q   (cpu_ready)
    );

    mbx_capture #(.DATA_W(DATA_W)) u_capture (
        .logic_clk (logic_clk),
        .logic_rst (logic_rst),
        .strobe_s  (strobe_s),
        .ack_s     (ack_s),
        .held_data (held_data),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .ready_q   (ready_q)
    );
endmodule

// File: tb/tb_mbx_bridge.sv
module tb_mbx_bridge;
    localparam int DATA_W = 8;
    localparam int NVEC   = 8;
    localparam logic [DATA_W-1:0] VEC [NVEC] =
        '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3};

    logic              logic_clk = 1'b0;
    logic              bus_clk   = 1'b0;
    logic              logic_rst = 1'b1;
    logic              bus_rst   = 1'b1;
    logic              bus_we    = 1'b0;
    logic [1:0]        bus_addr  = 2'd0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              cpu_ready;
    logic [DATA_W-1:0] out_byte;
    logic              out_valid;

    int checks = 0;
    int errors = 0;
    int cap_cnt = 0;
    logic [DATA_W-1:0] cap_log [64];
    logic              prev_valid = 1'b0;
    logic [DATA_W-1:0] prev_byte  = '0;

    always #2.5 logic_clk = ~logic_clk;
    always #6.5 bus_clk   = ~bus_clk;

    mbx_bridge #(.DATA_W(DATA_W)) dut (
        .logic_clk (logic_clk),
        .logic_rst (logic_rst),
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cpu_ready (cpu_ready),
        .out_byte  (out_byte),
        .out_valid (out_valid)
    );

    // logic-domain monitor: logs captures, checks pulse width and byte hold
    always @(negedge logic_clk) begin
        if (logic_rst) begin
            prev_valid <= 1'b0;
            prev_byte  <= out_byte;
        end else begin
            if (out_valid) begin
                if (cap_cnt < 64) cap_log[cap_cnt] = out_byte;
                cap_cnt = cap_cnt + 1;
                if (prev_valid) begin
                    errors = errors + 1;
                    $display("FAIL R3 out_valid width: actual 2+ cycles expected 1");
                end
            end else if (out_byte != prev_byte) begin
                errors = errors + 1;
                $display("FAIL R4 out_byte moved without valid: actual %h expected %h",
                         out_byte, prev_byte);
            end
            prev_valid <= out_valid;
            prev_byte  <= out_byte;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge bus_clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge bus_clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic wait_ready(input logic v, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge bus_clk);
            if (cpu_ready == v) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] b);
        bus_write(2'd0, b);
        bus_write(2'd1, 8'h00);
        bus_write(2'd1, 8'h01);
    endtask

    task automatic ack_cycle(input string req);
        bit ok;
        wait_ready(1'b0, ok);
        check(ok, req, int'(cpu_ready), 0);
        bus_write(2'd2, 8'h01);
        wait_ready(1'b1, ok);
        check(ok, req, int'(cpu_ready), 1);
        bus_write(2'd2, 8'h00);
        bus_idle(6);
    endtask

    initial begin
        #(200000 * 5);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int base;

        // R1 reset state
        bus_idle(4);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_byte == '0, "R1 byte in reset", int'(out_byte), 0);
        check(cpu_ready == 1'b0, "R1 ready in reset", int'(cpu_ready), 0);
        @(negedge bus_clk);
        bus_rst   = 1'b0;
        logic_rst = 1'b0;
        wait_ready(1'b1, ok);
        check(ok, "R1 ready after reset", int'(cpu_ready), 1);
        bus_idle(10);
        check(cap_cnt == 0, "R1 no capture after reset", cap_cnt, 0);

        // R2 data write alone
        bus_write(2'd0, 8'hA5);
        bus_idle(20);
        check(cap_cnt == 0, "R2 data write alone", cap_cnt, 0);
        check(cpu_ready == 1'b1, "R2 ready unchanged", int'(cpu_ready), 1);

        // R3 R5 R7 vector sequence
        for (int i = 0; i < NVEC; i++) begin
            base = cap_cnt;
            send_byte(VEC[i]);
            wait_ready(1'b0, ok);
            check(ok, "R5 ready falls", int'(cpu_ready), 0);
            check(cap_cnt == base + 1, "R7 one capture", cap_cnt, base + 1);
            check(cap_log[base] == VEC[i], "R3 captured byte",
                  int'(cap_log[base]), int'(VEC[i]));
            bus_write(2'd2, 8'h01);
            wait_ready(1'b1, ok);
            check(ok, "R5 ready rises after ack", int'(cpu_ready), 1);
            bus_write(2'd2, 8'h00);
            bus_idle(6);
        end
        check(cap_cnt == NVEC, "R7 total", cap_cnt, NVEC);

        // R8 strobe already 1, write 1 again
        base = cap_cnt;
        bus_write(2'd1, 8'h01);
        bus_idle(20);
        check(cap_cnt == base, "R8 repeated strobe", cap_cnt, base);
        check(cpu_ready == 1'b1, "R8 ready stays", int'(cpu_ready), 1);

        // R6 edge while taken
        base = cap_cnt;
        send_byte(8'h77);
        wait_ready(1'b0, ok);
        check(cap_cnt == base + 1 && cap_log[base] == 8'h77, "R6 setup capture",
              int'(cap_log[base]), 8'h77);
        send_byte(8'h99);
        bus_idle(20);
        check(cap_cnt == base + 1, "R6 edge while taken", cap_cnt, base + 1);
        ack_cycle("R6 ack cycle");
        check(cap_cnt == base + 1, "R6 no late capture", cap_cnt, base + 1);
        check(out_byte == 8'h77, "R6 byte kept", int'(out_byte), 8'h77);

        // R9 edge while acked
        base = cap_cnt;
        send_byte(8'h42);
        wait_ready(1'b0, ok);
        check(cap_cnt == base + 1, "R9 setup capture", cap_cnt, base + 1);
        bus_write(2'd2, 8'h01);
        wait_ready(1'b1, ok);
        check(ok, "R9 ready in acked", int'(cpu_ready), 1);
        send_byte(8'h24);
        bus_idle(20);
        check(cap_cnt == base + 1, "R9 edge while acked", cap_cnt, base + 1);
        bus_write(2'd2, 8'h00);
        bus_idle(10);
        check(cap_cnt == base + 1, "R9 no capture on ack clear", cap_cnt, base + 1);
        send_byte(8'h24);
        wait_ready(1'b0, ok);
        check(cap_cnt == base + 2 && cap_log[base + 1] == 8'h24, "R9 accepted after clear",
              int'(cap_log[base + 1]), 8'h24);
        ack_cycle("R9 ack cycle");

        // R1 reset mid-run
        base = cap_cnt;
        @(negedge bus_clk);
        bus_rst   = 1'b1;
        logic_rst = 1'b1;
        bus_idle(4);
        check(out_valid == 1'b0, "R1 valid in second reset", int'(out_valid), 0);
        check(out_byte == '0, "R1 byte in second reset", int'(out_byte), 0);
        check(cpu_ready == 1'b0, "R1 ready in second reset", int'(cpu_ready), 0);
        @(negedge bus_clk);
        bus_rst   = 1'b0;
        logic_rst = 1'b0;
        wait_ready(1'b1, ok);
        check(ok, "R1 ready after second reset", int'(cpu_ready), 1);
        bus_idle(10);
        check(cap_cnt == base, "R1 no spurious capture", cap_cnt, base);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule